// File: doc/BRIEF.md
# IR Carrier Modulation Generator

This block makes the square-wave carrier that an infrared transmitter uses to switch its LED during mark intervals. A small write-only register port sets four things: which clock source drives the modulation tick, how many ticks the carrier stays high, how many ticks it stays low, and two control bits. One bit enables the generator. The other sets the idle level of the output.

While enabled, the block counts ticks of the selected source and alternates between an on phase and an off phase. Each period starts with the on phase. It drives the carrier waveform out. It also raises a one-cycle strobe each time a full period ends, so that a symbol sequencer can count carrier cycles.

Software reprograms the carrier in a fixed order. It first disables the generator with the idle-high bit set. It then writes the counts, clears the idle-high bit and enables the generator again. Counts written while the carrier runs are held back until the current period has finished.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset, `carrier_out` is low and `period_stb` is low.
- R2: Bit 0 of the control register (word address 0) enables the generator, and bit 2 sets the idle level. While the generator is disabled, `carrier_out` equals bit 2 and `period_stb` stays low.
- R3: The count register (word address 1) holds the on length minus one in bits 31:16 and the off length minus one in bits 15:0, both counted in ticks. Each period is high for the on length and then low for the off length.
- R4: Control bits 13:12 select the tick source. 0 gives one tick per system clock cycle. 1 gives one tick per three `xtal_tick` pulses. 2 gives one tick every US_DIV cycles. 3 gives one tick every 10*US_DIV cycles.
- R5: `period_stb` is high for exactly one cycle at the end of each period. That cycle is the first high cycle of the next on phase.
- R6: A count written while the generator runs has no effect on the period in progress. It applies from the next period boundary onward.
- R7: With both counts set to zero, the period is two ticks long and high for one of them.
- R8: The cycle after the enable bit is set, `carrier_out` is high, because every run starts in the on phase.
- R9: While the generator stays enabled, `carrier_out` changes only in the cycle that follows a modulation tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address (0 control, 1 counts) |
| wr_data | input | DATA_W | Register write data |
| xtal_tick | input | 1 | One-cycle pulse at the crystal rate |
| carrier_out | output | 1 | Modulated carrier waveform |
| period_stb | output | 1 | One-cycle pulse at the end of each carrier period |

## Verification
The bench measures the length of every period and the number of high cycles in it, between successive strobes. It does this for all four tick sources and for the smallest count pair. A divider off by one, or a phase counter that compared against the wrong field, would shift both numbers by whole ticks.

The bench also rewrites the counts in the middle of a period. A design that loaded the new values at once would end the current period early or late, instead of finishing it and switching at the boundary.

It checks the idle level and the absence of strobes after the generator is disabled. It also checks that the carrier goes high right after enable. A design that kept counting while disabled, or that started a run in the off phase, would fail those checks.

// File: rtl/irc_pkg.sv
package irc_pkg;
  typedef enum logic [1:0] {
    SRC_SYS  = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_1US  = 2'd2,
    SRC_10US = 2'd3
  } irc_src_e;

  typedef enum logic {
    PH_ON  = 1'b0,
    PH_OFF = 1'b1
  } irc_phase_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_IDLE_BIT = 2;
  localparam int CTL_SEL_LSB  = 12;
endpackage

// File: rtl/irc_prescale.sv
module irc_prescale #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic pulse
);
  generate
    if (DIV <= 1) begin : g_pass
      assign pulse = step & ~clr;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          cnt_q <= '0;
        end else if (step) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end

      assign pulse = step & ~clr & (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/irc_regs.sv
module irc_regs
  import irc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int ADDR_CTRL = 0,
  parameter int ADDR_CNT  = 1,
  localparam int CNT_W    = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              en,
  output logic              idle_high,
  output irc_src_e          src_sel,
  output logic [CNT_W-1:0]  pend_on,
  output logic [CNT_W-1:0]  pend_off
);
  logic hit_ctrl, hit_cnt;

  assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign hit_cnt  = wr_en && (wr_addr == ADDR_W'(ADDR_CNT));

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      idle_high <= 1'b0;
      src_sel   <= SRC_SYS;
    end else if (hit_ctrl) begin
      en        <= wr_data[CTL_EN_BIT];
      idle_high <= wr_data[CTL_IDLE_BIT];
      src_sel   <= irc_src_e'(wr_data[CTL_SEL_LSB +: 2]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_on  <= '0;
      pend_off <= '0;
    end else if (hit_cnt) begin
      pend_on  <= wr_data[CNT_W +: CNT_W];
      pend_off <= wr_data[0 +: CNT_W];
    end
  end
endmodule

// File: rtl/irc_tick_gen.sv
module irc_tick_gen
  import irc_pkg::*;
#(
  parameter int US_DIV     = 100,
  parameter int TEN_RATIO  = 10,
  parameter int XTAL_RATIO = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  irc_src_e src_sel,
  input  logic     xtal_tick,
  output logic     tick
);
  logic us_p, ten_p, x_p, raw;
  logic [2:0] steps;
  logic [2:0] pulses;

  assign steps = {xtal_tick, us_p, 1'b1};

  genvar gi;
  generate
    for (gi = 0; gi < 3; gi++) begin : g_ps
      localparam int DV = (gi == 0) ? US_DIV : (gi == 1) ? TEN_RATIO : XTAL_RATIO;
      irc_prescale #(.DIV(DV)) u_ps (
        .clk  (clk),
        .rst  (rst),
        .clr  (~en),
        .step (steps[gi]),
        .pulse(pulses[gi])
      );
    end
  endgenerate

  assign us_p  = pulses[0];
  assign ten_p = pulses[1];
  assign x_p   = pulses[2];

  always_comb begin
    unique case (src_sel)
      SRC_SYS:  raw = 1'b1;
      SRC_XTAL: raw = x_p;
      SRC_1US:  raw = us_p;
      SRC_10US: raw = ten_p;
      default:  raw = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= en & raw;
  end
endmodule

// File: rtl/irc_phase.sv
module irc_phase
  import irc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             idle_high,
  input  logic             tick,
  input  logic [CNT_W-1:0] pend_on,
  input  logic [CNT_W-1:0] pend_off,
  output logic             carrier,
  output logic             stb
);
  irc_phase_e     phase_q;
  logic [CNT_W-1:0] cnt_q, act_on, act_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_ON;
      cnt_q   <= '0;
      act_on  <= '0;
      act_off <= '0;
      carrier <= 1'b0;
      stb     <= 1'b0;
    end else if (!en) begin
      phase_q <= PH_ON;
      cnt_q   <= '0;
      act_on  <= pend_on;
      act_off <= pend_off;
      carrier <= idle_high;
      stb     <= 1'b0;
    end else begin
      stb     <= 1'b0;
      carrier <= (phase_q == PH_ON);
      if (tick) begin
        if (phase_q == PH_ON) begin
          if (cnt_q == act_on) begin
            phase_q <= PH_OFF;
            cnt_q   <= '0;
            carrier <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == act_off) begin
            phase_q <= PH_ON;
            cnt_q   <= '0;
            carrier <= 1'b1;
            stb     <= 1'b1;
            act_on  <= pend_on;
            act_off <= pend_off;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import irc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int US_DIV     = 100,
  parameter int TEN_RATIO  = 10,
  parameter int XTAL_RATIO = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xtal_tick,
  output logic              carrier_out,
  output logic              period_stb
);
  localparam int CNT_W = DATA_W / 2;

  logic             ctl_en, ctl_idle, tick;
  irc_src_e         ctl_sel;
  logic [CNT_W-1:0] pend_on, pend_off;

  irc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .en       (ctl_en),
    .idle_high(ctl_idle),
    .src_sel  (ctl_sel),
    .pend_on  (pend_on),
    .pend_off (pend_off)
  );

  irc_tick_gen #(
    .US_DIV(US_DIV), .TEN_RATIO(TEN_RATIO), .XTAL_RATIO(XTAL_RATIO)
  ) u_tick (
    .clk      (clk),
    .rst      (rst),
    .en       (ctl_en),
    .src_sel  (ctl_sel),
    .xtal_tick(xtal_tick),
    .tick     (tick)
  );

  irc_phase #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .en       (ctl_en),
    .idle_high(ctl_idle),
    .tick     (tick),
    .pend_on  (pend_on),
    .pend_off (pend_off),
    .carrier  (carrier_out),
    .stb      (period_stb)
  );
endmodule

// File: rtl/irc_chk.sv
module irc_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic tick,
  input logic carrier,
  input logic stb
);
  // R2
  stb_only_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !stb);

  // R5
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);

  // R5
  stb_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    stb |-> (carrier && !$past(carrier)));

  // R8
  start_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |=> carrier);

  // R9
  carrier_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(en, 2) && !$past(tick)) |-> $stable(carrier));
endmodule

bind ir_carrier_gen irc_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (ctl_en),
  .tick   (tick),
  .carrier(carrier_out),
  .stb    (period_stb)
);

// File: tb/sim_ir_carrier_gen.sv
`timescale 1ns/1ps
module sim_ir_carrier_gen;
  localparam int DW = 32, AW = 4, USD = 5;

  typedef struct { int per; int hi; string tag; } exp_t;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, xtal_tick = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic carrier_out, period_stb;

  int n_chk = 0, n_fail = 0;
  exp_t q[$];
  bit armed = 1'b0;
  int win_len = 0, win_hi = 0;
  logic prev_car = 1'b0;

  ir_carrier_gen #(.DATA_W(DW), .ADDR_W(AW), .US_DIV(USD)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .xtal_tick(xtal_tick),
    .carrier_out(carrier_out), .period_stb(period_stb)
  );

  always #5 clk = ~clk;

  initial begin : xtal_gen
    int k;
    k = 0;
    forever begin
      @(posedge clk); #2;
      xtal_tick = (k == 3);
      k = (k == 3) ? 0 : k + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: one window per carrier period, bounded by strobes.
  always @(negedge clk) begin
    if (!rst) begin
      win_len++;
      win_hi += int'(carrier_out);
      if (period_stb) begin
        check(carrier_out && !prev_car, "R5 strobe at rising edge",
              int'({prev_car, carrier_out}), 1);
        if (armed && q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          check(win_len - 1 == e.per, {e.tag, " period"}, win_len - 1, e.per);
          check(win_hi - 1 == e.hi, {e.tag, " high"}, win_hi - 1, e.hi);
        end
        armed   = 1'b1;
        win_len = 1;
        win_hi  = 1;
      end
      prev_car = carrier_out;
    end
  end

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  function automatic logic [DW-1:0] ctl(input int sel, input bit idle, input bit en);
    return (DW'(sel) << 12) | (DW'(idle) << 2) | DW'(en);
  endfunction

  task automatic push(input int on_m1, input int off_m1, input int t, input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.per = (on_m1 + off_m1 + 2) * t;
      e.hi  = (on_m1 + 1) * t;
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic start(input int sel, input int on_m1, input int off_m1);
    wr(0, ctl(sel, 1'b1, 1'b0));
    wr(1, (DW'(on_m1) << 16) | DW'(off_m1));
    wr(0, ctl(sel, 1'b0, 1'b0));
    armed = 1'b0;
  endtask

  task automatic enable(input int sel);
    wr(0, ctl(sel, 1'b0, 1'b1));
    @(posedge clk); @(negedge clk);
    check(carrier_out === 1'b1, "R8 high after enable", int'(carrier_out), 1);
  endtask

  task automatic drain(input string tag);
    int g;
    g = 0;
    while (q.size() > 0 && g < 20000) begin
      @(posedge clk); #2; g++;
    end
    check(q.size() == 0, {tag, " periods observed"}, q.size(), 0);
    q.delete();
  endtask

  task automatic idle_check(input bit idle);
    int bad;
    wr(0, ctl(0, idle, 1'b0));
    @(posedge clk); @(posedge clk);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (period_stb || carrier_out !== idle) bad++;
    end
    check(bad == 0, "R2 disabled idle level, no strobe", bad, 0);
  endtask

  task automatic run_case(input int sel, input int on_m1, input int off_m1,
                          input int t, input string tag);
    start(sel, on_m1, off_m1);
    push(on_m1, off_m1, t, tag, 3);
    enable(sel);
    drain(tag);
    idle_check(1'b0);
  endtask

  initial begin : main
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(carrier_out === 1'b0, "R1 reset carrier", int'(carrier_out), 0);
    check(period_stb === 1'b0, "R1 reset strobe", int'(period_stb), 0);

    idle_check(1'b1);
    idle_check(1'b0);

    run_case(0, 3, 5, 1, "R3 sysclk 4/6");
    run_case(0, 0, 0, 1, "R7 minimum counts");
    run_case(2, 1, 2, USD, "R4 1us source");
    run_case(3, 0, 1, 10 * USD, "R4 10us source");
    run_case(1, 2, 0, 12, "R4 xtal/3 source");

    // R6: counts rewritten mid-period take effect at the next boundary
    start(0, 7, 7);
    push(7, 7, 1, "R6 old counts", 2);
    push(2, 3, 1, "R6 new counts", 3);
    enable(0);
    begin
      int g;
      g = 0;
      while (q.size() != 4 && g < 5000) begin
        @(posedge clk); #2; g++;
      end
    end
    wr(1, (DW'(2) << 16) | DW'(3));
    drain("R6 boundary update");
    idle_check(1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule